// File: doc/BRIEF.md
# Audio Frame Clock Generator

This block produces the timing for a two-slot serial audio link when the local port is the timing master. It runs on the master clock. A selectable prescale of 1, 2 or 4 turns the master clock into an internal clock enable. The enable drives a single phase count that spans one frame of 32 bit periods. A bit period is 8 enabled cycles, so a frame is 256 enabled cycles, and the frame rate equals the master clock rate divided by 256 times the prescale.

The block drives a bit clock and a long frame sync. The frame sync covers the whole first 16-bit slot. The block also gives a downstream shifter a bit index, a frame-start strobe and the internal enable itself. A new prescale is adopted only where one frame ends and the next begins, so no bit clock period is ever cut short.

A configuration-error flag compares a supplied nominal master clock rate in kHz against a ceiling of 12288 kHz for the internal rate. It also flags the unused prescale code.

Top module: `afcg_frame_clk`

## Requirements
- R1: While reset is low, and until internal reset release, the outputs read: bit clock 0, frame sync 1, bit index 0, frame-start 1, internal enable 0, configuration error 0, prescale 1. Internal reset releases on the second master clock rising edge after `rst_ni` rises, and the phase first advances on the third.
- R2: The prescale select `div_sel_i` is decoded as 2'b00 = 1, 2'b01 = 2 and 2'b10 = 4. The code 2'b11 is reserved: it leaves the active prescale unchanged.
- R3: The bit clock is low for 4 internal-enable cycles and then high for 4, giving a period of 8 × prescale master clock cycles. It changes only on an edge where the internal enable is high.
- R4: The frame sync is high during bit periods 0 to 15 and low during 16 to 31. A frame lasts 256 × prescale master clock cycles.
- R5: The 5-bit bit index counts 0 to 31 and wraps. It advances by one each time the bit clock falls.
- R6: The frame-start strobe is high for exactly the first internal-enable cycle of each frame, which is prescale master cycles long. It rises only when the bit index wraps from 31 to 0.
- R7: The prescale in effect changes only at a frame boundary. The value of `div_sel_i` on the last master cycle of a frame selects the prescale for the next frame.
- R8: One master clock edge after its inputs, `cfg_err_o` is high when `div_sel_i` is 2'b11 or when `mclk_khz_i` exceeds 12288 × the selected prescale. A value equal to that product is not an error.
- R9: After internal reset release, the internal enable `tick_o` is high on one master cycle out of every prescale cycles, and constantly high at prescale 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_sel_i | input | 2 | Prescale select code |
| mclk_khz_i | input | 16 | Nominal master clock rate in kHz |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Long frame sync |
| bit_idx_o | output | 5 | Bit index within the frame |
| frame_start_o | output | 1 | First internal cycle of a frame |
| tick_o | output | 1 | Internal clock enable |
| cfg_err_o | output | 1 | Configuration error flag |

## Verification
The bit clock, frame sync, bit index and frame-start strobe are decoded from the phase register, so they move on the master edge at which `tick_o` was high. `tick_o` itself is combinational from the prescale state, and `cfg_err_o` follows its inputs after exactly one edge. A prescale request only shows in the frame that follows the next boundary, which can be up to 1024 cycles later. The bench advances its own model on each rising edge and compares every output a quarter period later. Its period measurements therefore count whole master cycles between sampled rising edges, and a mid-frame prescale request is measured against the old period before that boundary.

// File: rtl/afcg_pkg.sv
package afcg_pkg;

  // Largest supported prescale; sizes the prescale counter.
  localparam int unsigned MAX_DIV = 4;

  typedef enum logic [1:0] {
    DIV_1    = 2'b00,
    DIV_2    = 2'b01,
    DIV_4    = 2'b10,
    DIV_RSVD = 2'b11
  } div_code_e;

  function automatic logic [2:0] div_factor(input div_code_e code);
    case (code)
      DIV_1:   div_factor = 3'd1;
      DIV_2:   div_factor = 3'd2;
      default: div_factor = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/afcg_rst_sync.sv
module afcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/afcg_prescale.sv
module afcg_prescale
  import afcg_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_DIV)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  div_code_e div_i,
  output logic      tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] term;
  logic             at_term;

  always_comb begin
    term    = CNT_W'(div_factor(div_i) - 3'd1);
    at_term = (cnt_q == term);
    cnt_d   = at_term ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // Enable is held off until the synchronised reset has released.
  assign tick_o = rst_ni & at_term;

endmodule

// File: rtl/afcg_frame_ctr.sv
module afcg_frame_ctr
  import afcg_pkg::*;
#(
  parameter int BIT_SUB    = 8,
  parameter int FRAME_BITS = 32,
  localparam int PH_W      = $clog2(BIT_SUB * FRAME_BITS),
  localparam int SUB_W     = $clog2(BIT_SUB),
  localparam int IDX_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  div_code_e        div_sel_i,
  output div_code_e        div_o,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             frame_start_o
);

  localparam int PH_LAST = BIT_SUB * FRAME_BITS - 1;
  localparam int HALF    = FRAME_BITS / 2;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  div_code_e       div_q;
  div_code_e       div_d;
  logic            wrap;

  always_comb begin
    wrap  = tick_i && (ph_q == PH_W'(PH_LAST));
    ph_d  = ph_q;
    div_d = div_q;
    if (tick_i) ph_d = wrap ? '0 : ph_q + PH_W'(1);
    if (wrap && (div_sel_i != DIV_RSVD)) div_d = div_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      div_q <= DIV_1;
    end else begin
      ph_q  <= ph_d;
      div_q <= div_d;
    end
  end

  always_comb begin
    bit_idx_o     = ph_q[PH_W-1:SUB_W];
    bclk_o        = ph_q[SUB_W-1];
    fsync_o       = (bit_idx_o < IDX_W'(HALF));
    frame_start_o = (ph_q == '0);
    div_o         = div_q;
  end

endmodule

// File: rtl/afcg_cfg_check.sv
module afcg_cfg_check
  import afcg_pkg::*;
#(
  parameter int unsigned LIMIT_KHZ = 12288,
  parameter int          KHZ_W     = 16,
  localparam int         CMP_W     = KHZ_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  div_code_e        div_sel_i,
  input  logic [KHZ_W-1:0] mclk_khz_i,
  output logic             err_o
);

  logic [CMP_W-1:0] ceiling;
  logic             err_d;
  logic             err_q;

  always_comb begin
    ceiling = CMP_W'(LIMIT_KHZ) * CMP_W'(div_factor(div_sel_i));
    err_d   = (div_sel_i == DIV_RSVD) || (CMP_W'(mclk_khz_i) > ceiling);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

endmodule

// File: rtl/afcg_frame_clk.sv
module afcg_frame_clk
  import afcg_pkg::*;
#(
  parameter int          BIT_SUB    = 8,
  parameter int          FRAME_BITS = 32,
  parameter int unsigned LIMIT_KHZ  = 12288,
  parameter int          KHZ_W      = 16,
  localparam int         IDX_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic [KHZ_W-1:0] mclk_khz_i,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             frame_start_o,
  output logic             tick_o,
  output logic             cfg_err_o
);

  logic      rst_n_int;
  div_code_e div_req;
  div_code_e div_act;

  assign div_req = div_code_e'(div_sel_i);

  afcg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  afcg_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .div_i  (div_act),
    .tick_o (tick_o)
  );

  afcg_frame_ctr #(
    .BIT_SUB    (BIT_SUB),
    .FRAME_BITS (FRAME_BITS)
  ) u_frm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_int),
    .tick_i        (tick_o),
    .div_sel_i     (div_req),
    .div_o         (div_act),
    .bclk_o        (bclk_o),
    .fsync_o       (fsync_o),
    .bit_idx_o     (bit_idx_o),
    .frame_start_o (frame_start_o)
  );

  afcg_cfg_check #(
    .LIMIT_KHZ (LIMIT_KHZ),
    .KHZ_W     (KHZ_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .div_sel_i  (div_req),
    .mclk_khz_i (mclk_khz_i),
    .err_o      (cfg_err_o)
  );

endmodule

// File: rtl/afcg_frame_clk_chk.sv
module afcg_frame_clk_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_n_int,
  input logic [1:0]       div_sel_i,
  input logic [1:0]       div_act,
  input logic             tick_o,
  input logic             bclk_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic             frame_start_o,
  input logic             cfg_err_o
);

  // R3: bit clock moves only on an enabled edge
  p_bclk_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !$past(tick_o) |-> $stable(bclk_o));

  // R5: bit index only ever steps by one, modulo the frame length
  p_idx_step_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (bit_idx_o != $past(bit_idx_o)) |-> (bit_idx_o == IDX_W'($past(bit_idx_o) + 1'b1)));

  // R6: frame-start rises only where the index wraps
  p_fstart_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $rose(frame_start_o) |-> ($past(bit_idx_o) == '1));

  // R7: active prescale changes only at a frame boundary
  p_div_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (div_act != $past(div_act)) |-> frame_start_o);

  // R8: reserved code raises the error one edge later
  p_err_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($past(rst_n_int) && ($past(div_sel_i) == 2'b11)) |-> cfg_err_o);

endmodule

bind afcg_frame_clk afcg_frame_clk_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_n_int     (rst_n_int),
  .div_sel_i     (div_sel_i),
  .div_act       (div_act),
  .tick_o        (tick_o),
  .bclk_o        (bclk_o),
  .bit_idx_o     (bit_idx_o),
  .frame_start_o (frame_start_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/test_afcg_frame_clk.sv
module test_afcg_frame_clk;

  localparam int T = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [15:0] khz = 16'd8192;
  logic        bclk_o, fsync_o, frame_start_o, tick_o, cfg_err_o;
  logic [4:0]  bit_idx_o;

  int checks = 0;
  int errors = 0;
  int rel = 0, m_cnt = 0, m_ph = 0, m_div = 1;
  bit m_err = 1'b0;

  always #(T/2) clk = ~clk;

  afcg_frame_clk i_afcg_frame_clk (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .div_sel_i     (sel),
    .mclk_khz_i    (khz),
    .bclk_o        (bclk_o),
    .fsync_o       (fsync_o),
    .bit_idx_o     (bit_idx_o),
    .frame_start_o (frame_start_o),
    .tick_o        (tick_o),
    .cfg_err_o     (cfg_err_o)
  );

  function automatic int fac(input logic [1:0] c);
    case (c)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: phase 0..255, prescale count, reset release delay of two edges.
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rel = 0; m_cnt = 0; m_ph = 0; m_div = 1; m_err = 1'b0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      m_err = (sel == 2'b11) || (int'(khz) > 12288 * fac(sel));
      if (m_cnt == m_div - 1) begin
        m_cnt = 0;
        if (m_ph == 255) begin
          m_ph = 0;
          if (sel != 2'b11) m_div = fac(sel);
        end else m_ph++;
      end else m_cnt++;
    end
  end

  always @(posedge clk) begin
    #(T/4);
    chk("R3", "bclk",        int'(bclk_o),        int'((m_ph % 8) >= 4));
    chk("R4", "fsync",       int'(fsync_o),       int'(m_ph < 128));
    chk("R5", "bit_idx",     int'(bit_idx_o),     m_ph / 8);
    chk("R6", "frame_start", int'(frame_start_o), int'(m_ph == 0));
    chk("R9", "tick",        int'(tick_o),        int'(rel >= 2 && m_cnt == m_div - 1));
    chk("R8", "cfg_err",     int'(cfg_err_o),     int'(m_err));
  end

  task automatic wait_pos();
    @(posedge clk);
    #(T/4);
  endtask

  // Master cycles between two consecutive rising edges of bclk (0) or frame_start (1).
  task automatic period_of(input bit use_fs, output int n);
    bit prev, cur;
    prev = use_fs ? frame_start_o : bclk_o;
    forever begin
      wait_pos();
      cur = use_fs ? frame_start_o : bclk_o;
      if (!prev && cur) break;
      prev = cur;
    end
    n = 0;
    prev = cur;
    forever begin
      wait_pos();
      n++;
      cur = use_fs ? frame_start_o : bclk_o;
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic reset_state_checks();
    chk("R1", "reset bclk",   int'(bclk_o),        0);
    chk("R1", "reset fsync",  int'(fsync_o),       1);
    chk("R1", "reset idx",    int'(bit_idx_o),     0);
    chk("R1", "reset fstart", int'(frame_start_o), 1);
    chk("R1", "reset tick",   int'(tick_o),        0);
    chk("R1", "reset err",    int'(cfg_err_o),     0);
  endtask

  initial begin
    int n;
    repeat (3) wait_pos();
    reset_state_checks();
    @(negedge clk) rst_ni = 1'b1;
    wait_pos();
    chk("R1", "tick after first edge", int'(tick_o), 0);
    wait_pos();
    chk("R1", "tick after second edge", int'(tick_o), 1);

    period_of(1'b1, n); chk("R2", "frame period code 00", n, 256);
    period_of(1'b0, n); chk("R3", "bclk period at 1", n, 8);

    // Request prescale 2 mid-frame; old period must hold until the boundary.
    while (bit_idx_o != 5'd4) wait_pos();
    @(negedge clk) sel = 2'b01;
    period_of(1'b0, n); chk("R7", "bclk period before boundary", n, 8);
    period_of(1'b1, n); chk("R2", "frame period code 01", n, 512);
    period_of(1'b0, n); chk("R3", "bclk period at 2", n, 16);

    @(negedge clk) sel = 2'b10;
    period_of(1'b1, n); chk("R4", "frame period code 10", n, 1024);
    period_of(1'b0, n); chk("R3", "bclk period at 4", n, 32);

    @(negedge clk) sel = 2'b11;
    wait_pos();
    chk("R8", "err on reserved code", int'(cfg_err_o), 1);
    period_of(1'b1, n); chk("R2", "reserved code keeps 4", n, 1024);

    @(negedge clk) begin khz = 16'd24576; sel = 2'b01; end
    wait_pos();
    chk("R8", "24576 kHz at 2 equals ceiling", int'(cfg_err_o), 0);
    @(negedge clk) sel = 2'b00;
    wait_pos();
    chk("R8", "24576 kHz at 1 over ceiling", int'(cfg_err_o), 1);
    @(negedge clk) khz = 16'd12288;
    wait_pos();
    chk("R8", "12288 kHz at 1", int'(cfg_err_o), 0);
    period_of(1'b1, n);
    period_of(1'b1, n); chk("R7", "frame period after return to 1", n, 256);

    @(negedge clk) rst_ni = 1'b0;
    wait_pos();
    reset_state_checks();
    @(negedge clk) rst_ni = 1'b1;
    period_of(1'b1, n); chk("R4", "frame period after reset", n, 256);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule